// File: doc/BRIEF.md
# Supply Low-Voltage Monitor Status Controller

This block is the digital half of a supply-voltage watchdog. Two analog comparators report whether the supply has dropped under the falling trip level and whether it has climbed over the rising trip level. The block brings both flags into its clock domain through a synchroniser. A two-state machine turns them into a hysteresis status. That status holds a system reset request asserted from the moment the supply sags until it has clearly recovered. Because release waits for the higher threshold, the chip does not cycle in and out of reset while the supply hovers near the lower one.

When the status goes from clear to set, the block latches a low-voltage interrupt flag. An enable bit decides whether that flag reaches the CPU. Software sees the status, the flag and the enable through a single 8-bit status register. Writing a one to the flag position acknowledges the flag. A 2-bit trip-range selection from the configuration space passes straight through to the analog comparators, which use it to pick 5 V or 3 V thresholds.

The state machine has two states. `ST_SUPPLY_OK` is the reset state. `ST_SUPPLY_LOW` is entered from `ST_SUPPLY_OK` on a synchronised below-falling report (transition TRIP). It returns to `ST_SUPPLY_OK` only on a synchronised above-rising report with no below-falling report (transition RECOVER). In every other case each state stays where it is (transition HOLD).

Top module: `lvmon_ctrl`

## Requirements
- R1: Three clock edges after the below-falling comparator input goes high, the status bit (register bit 7) reads 1.
- R2: Three clock edges after the above-rising input goes high, with the below-falling input low, the status bit reads 0.
- R3: While both comparator inputs are low, the status bit keeps its value.
- R4: The reset request output equals the status bit. Once asserted, it deasserts only after an above-rising report.
- R5: The status register reads bit 7 = status, bit 6 = interrupt flag and bit 0 = interrupt enable. Bits 5 to 1 read 0.
- R6: A write with bit 6 = 1 clears the interrupt flag by the next edge. A write with bit 6 = 0 leaves the flag unchanged. Writes to bits 7 and 5..1 have no effect.
- R7: The interrupt request output is 1 exactly when both the flag and the enable (bit 0, written by any register write) are 1.
- R8: While reset is asserted, the register reads 0x00 and both the reset request and the interrupt request are 0.
- R9: The trip-range selection output equals the 2-bit configuration input for all four values.
- R10: The interrupt flag sets on the same edge on which the status bit goes from 0 to 1.
- R11: If an acknowledge write falls on the edge where the flag is set, the flag ends up set.
- R12: If both comparator inputs are high, the below-falling report wins and the status becomes or stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_below_fall | input | 1 | Asynchronous comparator: supply below falling trip level |
| cmp_above_rise | input | 1 | Asynchronous comparator: supply above rising trip level |
| trip_sel_cfg | input | 2 | Trip-range selection from configuration |
| trip_sel_out | output | 2 | Trip-range selection to the comparators |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read data |
| lv_rst_req | output | 1 | System reset request |
| lv_irq_req | output | 1 | Low-voltage interrupt request |

## Verification
A wrong machine state shows up at once on both bit 7 and the reset request, three edges after the comparator input that should have moved it. Every combination of comparator inputs is applied from each state, so a swapped priority or a missing hold shows on the very next sample. A fault in flag handling, such as a lost set during an acknowledge or a clear on a zero write, shows on bit 6 and on the interrupt request one edge after the write. Wrong bit placement is exposed by sweeping the write data patterns against a known flag state.

// File: rtl/lvmon_pkg.sv
package lvmon_pkg;

    typedef enum logic {
        ST_SUPPLY_OK  = 1'b0,
        ST_SUPPLY_LOW = 1'b1
    } lvm_state_e;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned STATUS_BIT = 7;
    localparam int unsigned FLAG_BIT   = 6;
    localparam int unsigned EN_BIT     = 0;
    localparam int unsigned TSEL_W     = 2;

endpackage

// File: rtl/lvmon_sync.sv
module lvmon_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/lvmon_fsm.sv
module lvmon_fsm
    import lvmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below_s,
    input  logic above_s,
    output logic status,
    output logic rst_req,
    output logic trip_pulse
);

    lvm_state_e state_q, state_d;

    // next-state: below-falling report has precedence over above-rising
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SUPPLY_OK: begin
                if (below_s) state_d = ST_SUPPLY_LOW;          // TRIP
            end
            ST_SUPPLY_LOW: begin
                if (!below_s && above_s) state_d = ST_SUPPLY_OK; // RECOVER
            end
            default: state_d = ST_SUPPLY_OK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SUPPLY_OK;
        else        state_q <= state_d;
    end

    always_comb begin
        status     = 1'b0;
        rst_req    = 1'b0;
        trip_pulse = 1'b0;
        unique case (state_q)
            ST_SUPPLY_OK: begin
                trip_pulse = (state_d == ST_SUPPLY_LOW);
            end
            ST_SUPPLY_LOW: begin
                status  = 1'b1;
                rst_req = 1'b1;
            end
            default: ;
        endcase
    end

    AST_BELOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        below_s |=> status); // R1
    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!below_s && above_s) |=> !status); // R2
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!below_s && !above_s) |=> $stable(status)); // R3
    AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> $past(above_s && !below_s)); // R4

endmodule

// File: rtl/lvmon_regs.sv
module lvmon_regs
    import lvmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             status,
    input  logic             trip_pulse,
    input  logic             wr,
    input  logic             wr_ack,
    input  logic             wr_en,
    output logic [REG_W-1:0] rdata,
    output logic             irq_req
);

    logic flag_q;
    logic en_q;

    // set takes priority over a coincident acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             flag_q <= 1'b0;
        else if (trip_pulse)    flag_q <= 1'b1;
        else if (wr && wr_ack)  flag_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  en_q <= 1'b0;
        else if (wr) en_q <= wr_en;
    end

    always_comb begin
        rdata             = '0;
        rdata[STATUS_BIT] = status;
        rdata[FLAG_BIT]   = flag_q;
        rdata[EN_BIT]     = en_q;
    end

    assign irq_req = flag_q & en_q;

    AST_FLAG_ON_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status) |-> flag_q); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_pulse && wr && wr_ack) |=> flag_q); // R11
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_ack && !trip_pulse) |=> !flag_q); // R6
    AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr && wr_ack)) |=> flag_q); // R6

endmodule

// File: rtl/lvmon_ctrl.sv
module lvmon_ctrl
    import lvmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_below_fall,
    input  logic              cmp_above_rise,
    input  logic [TSEL_W-1:0] trip_sel_cfg,
    output logic [TSEL_W-1:0] trip_sel_out,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              lv_rst_req,
    output logic              lv_irq_req
);

    localparam int unsigned CMP_W = 2;

    logic [CMP_W-1:0] cmp_s;
    logic             status;
    logic             trip_pulse;
    logic             unused_wdata;

    assign unused_wdata = ^{reg_wdata[REG_W-1:FLAG_BIT+1], reg_wdata[FLAG_BIT-1:EN_BIT+1]};

    lvmon_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (CMP_W)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cmp_above_rise, cmp_below_fall}),
        .sync_out (cmp_s)
    );

    lvmon_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .below_s    (cmp_s[0]),
        .above_s    (cmp_s[1]),
        .status     (status),
        .rst_req    (lv_rst_req),
        .trip_pulse (trip_pulse)
    );

    lvmon_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .status     (status),
        .trip_pulse (trip_pulse),
        .wr         (reg_wr),
        .wr_ack     (reg_wdata[FLAG_BIT]),
        .wr_en      (reg_wdata[EN_BIT]),
        .rdata      (reg_rdata),
        .irq_req    (lv_irq_req)
    );

    assign trip_sel_out = trip_sel_cfg;

    AST_RST_TRACKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        lv_rst_req == reg_rdata[STATUS_BIT]); // R4
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        lv_irq_req |-> (reg_rdata[EN_BIT] && reg_rdata[FLAG_BIT])); // R7

endmodule

// File: tb/lvmon_ctrl_tb_top.sv
`timescale 1ns/1ps
module lvmon_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_below_fall = 1'b0;
    logic       cmp_above_rise = 1'b0;
    logic [1:0] trip_sel_cfg = 2'b00;
    logic [1:0] trip_sel_out;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       lv_rst_req;
    logic       lv_irq_req;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lvmon_ctrl dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmp_below_fall (cmp_below_fall),
        .cmp_above_rise (cmp_above_rise),
        .trip_sel_cfg   (trip_sel_cfg),
        .trip_sel_out   (trip_sel_out),
        .reg_wr         (reg_wr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .lv_rst_req     (lv_rst_req),
        .lv_irq_req     (lv_irq_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive comparators and wait for them to reach the state register
    task automatic apply_cmp(input logic b, input logic a);
        cmp_below_fall = b;
        cmp_above_rise = a;
        wait_n(3);
    endtask

    task automatic reg_write(input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        wait_n(1);
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
    endtask

    initial begin
        wait_n(1);
        // R8: reset state
        chk("R8 rdata", reg_rdata, 8'h00);
        chk("R8 rst_req/irq", {6'd0, lv_rst_req, lv_irq_req}, 8'h00);
        rst_n = 1'b1;
        wait_n(1);

        // R9: trip selection pass-through
        for (int t = 0; t < 4; t++) begin
            trip_sel_cfg = 2'(t);
            #1;
            chk("R9 trip_sel", {6'd0, trip_sel_out}, 8'(t));
        end

        // R1 R2 R3 R12 R4 R10 R7: all input pairs from both states
        reg_write(8'h01);
        for (int st = 0; st < 2; st++) begin
            for (int c = 0; c < 4; c++) begin
                logic b, a, exp_st, rose;
                b = c[0];
                a = c[1];
                apply_cmp(st[0], !st[0]);
                reg_write(8'h41);
                apply_cmp(b, a);
                exp_st = b ? 1'b1 : (a ? 1'b0 : st[0]);
                rose   = !st[0] && exp_st;
                chk(b ? (a ? "R12 status" : "R1 status") : (a ? "R2 status" : "R3 status"),
                    {7'd0, reg_rdata[7]}, {7'd0, exp_st});
                chk("R4 rst_req", {7'd0, lv_rst_req}, {7'd0, exp_st});
                chk("R10 flag", {7'd0, reg_rdata[6]}, {7'd0, rose});
                chk("R7 irq", {7'd0, lv_irq_req}, {7'd0, rose});
            end
        end

        // R4: reset request holds while supply sits between thresholds
        apply_cmp(1'b1, 1'b0);
        apply_cmp(1'b0, 1'b0);
        wait_n(5);
        chk("R4 hold in band", {7'd0, lv_rst_req}, 8'd1);
        apply_cmp(1'b0, 1'b1);
        chk("R4 release", {7'd0, lv_rst_req}, 8'd0);

        // R5 R6 R7: write-pattern sweep with the flag set
        for (int v = 0; v < 8; v++) begin
            logic [7:0] d;
            logic exp_flag;
            apply_cmp(1'b0, 1'b1);
            reg_write(8'h40);
            apply_cmp(1'b1, 1'b0);
            d = {v[2], v[1], v[2] ? 5'b11111 : 5'b00000, v[0]};
            reg_write(d);
            exp_flag = !v[1];
            chk("R5 R6 rdata", reg_rdata, {1'b1, exp_flag, 5'b00000, v[0]});
            chk("R7 irq", {7'd0, lv_irq_req}, {7'd0, exp_flag & v[0]});
        end

        // R11: acknowledge on the edge that sets the flag
        apply_cmp(1'b0, 1'b1);
        reg_write(8'h41);
        cmp_below_fall = 1'b1;
        cmp_above_rise = 1'b0;
        wait_n(2);
        reg_wr    = 1'b1;
        reg_wdata = 8'h41;
        wait_n(1);
        reg_wr    = 1'b0;
        reg_wdata = 8'h00;
        chk("R11 flag", {7'd0, reg_rdata[6]}, 8'd1);
        chk("R11 status", {7'd0, reg_rdata[7]}, 8'd1);

        // R8: reset mid-run clears everything
        rst_n = 1'b0;
        #1;
        chk("R8 rdata", reg_rdata, 8'h00);
        chk("R8 rst_req/irq", {6'd0, lv_rst_req, lv_irq_req}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule